// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block is a small data cache that sits between a CPU port and a slower backing memory. The CPU issues single-byte reads and writes. Every line of the cache holds a valid flag, a dirty flag, a tag and one data block. An access that finds its block returns quickly. An access that does not find it first moves whole blocks to and from memory, then completes.

Stores use write-back with write-allocate. A store marks its line modified and does not touch memory. A modified line reaches memory only when another block displaces it. If a store misses on a line that holds modified data, the controller first writes the old block back. It then fetches the new block, merges the stored byte into it and marks the line dirty.

The CPU offers a request while `cpuReady` is high. It receives a one-cycle `cpuDone` pulse together with the read byte and a hit flag. The memory side holds a request until it receives an acknowledge, one handshake per block transfer.

Top module: `dm_wb_cache`

## Requirements
- R1: The CPU address splits into three fields. The low log2(BLOCK_BYTES) bits select a byte within the block. The next log2(LINES) bits select the line. All remaining high bits form the tag. A refill reads memory at the requested tag and index with the byte field set to zero.
- R2: An access hits only when the selected line is valid and its stored tag equals the address tag. A line with a matching tag that is not valid counts as a miss. `cpuHit` is high with `cpuDone` exactly when the access hit.
- R3: On a read, `cpuRdata` carries the byte of the block selected by the byte field while `cpuDone` is high.
- R4: Synchronous reset clears every valid and dirty flag. After reset, `cpuReady` is high, `memReq` is low, and the first access to any line misses.
- R5: Memory transfers always move a whole block. `memAddr` has its byte-field bits at zero whenever `memReq` is high.
- R6: A miss on a line that is valid and dirty writes that line's block back first. The write-back address is built from the stored tag and the index. The refill read is issued only after the write-back has been acknowledged.
- R7: A miss on a clean or invalid line performs the refill alone, with no write-back. A read leaves the line valid and clean.
- R8: A write updates only the addressed byte and marks the line dirty. A write miss loads the block first (after any write-back) and then applies the byte.
- R9: A request is taken only while `cpuReady` is high. `cpuReady` stays low from acceptance through the whole miss sequence. `cpuDone` is a single-cycle pulse.
- R10: Once raised, `memReq` stays high, with `memAddr` and `memWe` unchanged, until `memAck` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpuReq | input | 1 | CPU request strobe, taken while cpuReady is high |
| cpuWe | input | 1 | 1 = write byte, 0 = read byte |
| cpuAddr | input | ADDR_W | Byte address |
| cpuWdata | input | 8 | Byte to store |
| cpuReady | output | 1 | Controller idle and able to take a request |
| cpuDone | output | 1 | One-cycle completion pulse |
| cpuHit | output | 1 | Access hit, valid with cpuDone |
| cpuRdata | output | 8 | Read byte, valid with cpuDone on reads |
| memReq | output | 1 | Block transfer request, held until memAck |
| memWe | output | 1 | 1 = block write-back, 0 = block refill |
| memAddr | output | ADDR_W | Block-aligned memory address |
| memWdata | output | 8*BLOCK_BYTES | Block being written back |
| memRdata | input | 8*BLOCK_BYTES | Refill block, valid with memAck |
| memAck | input | 1 | Single-cycle transfer acknowledge |

## Verification
The checks assume that the memory answers each request with a single-cycle `memAck` pulse. They also assume the memory never acknowledges while `memReq` is low, and that refill data is valid in the acknowledge cycle. The bench's memory responder pulses `memAck` for one cycle after a random delay, and only while a request is pending. It then drops `memAck` before it looks at the next request. On the CPU side, the bench raises `cpuReq` only after it has seen `cpuReady` high, holds it for a single cycle, and waits for `cpuDone` before the next access. Random traces keep to the full address range, with tags drawn so that lines are often displaced.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WRITEBACK,
    ST_REFILL,
    ST_RESPOND
  } ctrl_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;   // capture CPU request fields
    logic captureRd;  // load read byte register
    logic storeByte;  // merge write byte, set dirty
    logic fillLine;   // install refill block, set valid, clear dirty
    logic selVictim;  // memory address from stored tag
  } dp_strobe_t;

endpackage

// File: rtl/dmc_datapath.sv
module dmc_datapath
  import dmc_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int LINES       = 8,
  parameter int BLOCK_BYTES = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  dp_strobe_t               strobe,
  input  logic                     cpuWe,
  input  logic [ADDR_W-1:0]        cpuAddr,
  input  logic [7:0]               cpuWdata,
  input  logic [BLOCK_BYTES*8-1:0] memRdata,
  output logic                     lineHit,
  output logic                     victimDirty,
  output logic                     reqWe,
  output logic [7:0]               cpuRdata,
  output logic [ADDR_W-1:0]        memAddr,
  output logic [BLOCK_BYTES*8-1:0] memWdata
);
  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int BLK_W = BLOCK_BYTES * 8;

  logic [ADDR_W-1:0] reqAddr;
  logic [7:0]        reqData;
  logic [LINES-1:0]  validBits;
  logic [LINES-1:0]  dirtyBits;
  logic [TAG_W-1:0]  tagArr  [LINES];
  logic [BLK_W-1:0]  dataArr [LINES];
  logic [7:0]        rdReg;

  logic [OFF_W-1:0] reqOff;
  logic [IDX_W-1:0] reqIdx;
  logic [TAG_W-1:0] reqTag;

  assign reqOff = reqAddr[OFF_W-1:0];
  assign reqIdx = reqAddr[OFF_W +: IDX_W];
  assign reqTag = reqAddr[ADDR_W-1 -: TAG_W];

  assign lineHit     = validBits[reqIdx] && (tagArr[reqIdx] == reqTag);
  assign victimDirty = validBits[reqIdx] && dirtyBits[reqIdx];
  assign memWdata    = dataArr[reqIdx];
  assign memAddr     = strobe.selVictim ? {tagArr[reqIdx], reqIdx, {OFF_W{1'b0}}}
                                        : {reqTag, reqIdx, {OFF_W{1'b0}}};
  assign cpuRdata    = rdReg;

  // request capture and read byte
  always_ff @(posedge clk) begin
    if (rst) begin
      reqAddr <= '0;
      reqWe   <= 1'b0;
      reqData <= '0;
      rdReg   <= '0;
    end else begin
      if (strobe.latchReq) begin
        reqAddr <= cpuAddr;
        reqWe   <= cpuWe;
        reqData <= cpuWdata;
      end
      if (strobe.captureRd)
        rdReg <= dataArr[reqIdx][{reqOff, 3'b000} +: 8];
    end
  end

  // per-line state flags
  always_ff @(posedge clk) begin
    if (rst) begin
      validBits <= '0;
      dirtyBits <= '0;
    end else if (strobe.fillLine) begin
      validBits[reqIdx] <= 1'b1;
      dirtyBits[reqIdx] <= 1'b0;
    end else if (strobe.storeByte) begin
      dirtyBits[reqIdx] <= 1'b1;
    end
  end

  // tag and block storage, one slice per line
  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (reqIdx == IDX_W'(g)) begin
        if (strobe.fillLine) begin
          tagArr[g]  <= reqTag;
          dataArr[g] <= memRdata;
        end else if (strobe.storeByte) begin
          dataArr[g][{reqOff, 3'b000} +: 8] <= reqData;
        end
      end
    end
  end

endmodule

// File: rtl/dmc_control.sv
module dmc_control
  import dmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cpuReq,
  input  logic       lineHit,
  input  logic       victimDirty,
  input  logic       reqWe,
  input  logic       memAck,
  output dp_strobe_t strobe,
  output logic       cpuReady,
  output logic       cpuDone,
  output logic       cpuHit,
  output logic       memReq,
  output logic       memWe
);
  ctrl_state_e state, nextState;
  logic        missSeen;

  always_comb begin
    nextState = state;
    strobe    = '0;
    cpuReady  = 1'b0;
    cpuDone   = 1'b0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        cpuReady = 1'b1;
        if (cpuReq) begin
          strobe.latchReq = 1'b1;
          nextState       = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (lineHit) begin
          strobe.storeByte = reqWe;
          strobe.captureRd = !reqWe;
          nextState        = ST_RESPOND;
        end else begin
          nextState = victimDirty ? ST_WRITEBACK : ST_REFILL;
        end
      end
      ST_WRITEBACK: begin
        memReq           = 1'b1;
        memWe            = 1'b1;
        strobe.selVictim = 1'b1;
        if (memAck) nextState = ST_REFILL;
      end
      ST_REFILL: begin
        memReq = 1'b1;
        if (memAck) begin
          strobe.fillLine = 1'b1;
          nextState       = ST_LOOKUP;
        end
      end
      ST_RESPOND: begin
        cpuDone   = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign cpuHit = cpuDone && !missSeen;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      missSeen <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE)
        missSeen <= 1'b0;
      else if (state == ST_LOOKUP && !lineHit)
        missSeen <= 1'b1;
    end
  end

endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache
  import dmc_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int LINES       = 8,
  parameter int BLOCK_BYTES = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cpuReq,
  input  logic                     cpuWe,
  input  logic [ADDR_W-1:0]        cpuAddr,
  input  logic [7:0]               cpuWdata,
  output logic                     cpuReady,
  output logic                     cpuDone,
  output logic                     cpuHit,
  output logic [7:0]               cpuRdata,
  output logic                     memReq,
  output logic                     memWe,
  output logic [ADDR_W-1:0]        memAddr,
  output logic [BLOCK_BYTES*8-1:0] memWdata,
  input  logic [BLOCK_BYTES*8-1:0] memRdata,
  input  logic                     memAck
);
  dp_strobe_t strobe;
  logic       lineHit;
  logic       victimDirty;
  logic       reqWe;

  dmc_control u_ctrl (
    .clk(clk), .rst(rst), .cpuReq(cpuReq), .lineHit(lineHit),
    .victimDirty(victimDirty), .reqWe(reqWe), .memAck(memAck),
    .strobe(strobe), .cpuReady(cpuReady), .cpuDone(cpuDone),
    .cpuHit(cpuHit), .memReq(memReq), .memWe(memWe)
  );

  dmc_datapath #(.ADDR_W(ADDR_W), .LINES(LINES), .BLOCK_BYTES(BLOCK_BYTES)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .memRdata(memRdata), .lineHit(lineHit),
    .victimDirty(victimDirty), .reqWe(reqWe), .cpuRdata(cpuRdata),
    .memAddr(memAddr), .memWdata(memWdata)
  );

endmodule

// File: rtl/dm_wb_cache_checker.sv
module dm_wb_cache_checker #(
  parameter int ADDR_W      = 8,
  parameter int BLOCK_BYTES = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cpuReq,
  input logic              cpuReady,
  input logic              cpuDone,
  input logic              memReq,
  input logic              memWe,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr
);
  localparam int OFF_W = $clog2(BLOCK_BYTES);

  // R9: accepted request drops ready on the next cycle
  p_accept_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (cpuReq && cpuReady) |=> !cpuReady);

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    cpuDone |=> !cpuDone);

  // R9: no memory traffic while idle
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    cpuReady |-> !memReq);

  // R10: pending request holds address and direction
  p_mem_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)));

  // R5: block-aligned transfers only
  p_aligned_r5: assert property (@(posedge clk) disable iff (rst)
    memReq |-> (memAddr[OFF_W-1:0] == '0));

  // R6: an acknowledged write-back is followed by the refill read
  p_wb_then_fill_r6: assert property (@(posedge clk) disable iff (rst)
    (memReq && memWe && memAck) |=> (memReq && !memWe));

endmodule

bind dm_wb_cache dm_wb_cache_checker #(.ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES)) u_chk (
  .clk(clk), .rst(rst), .cpuReq(cpuReq), .cpuReady(cpuReady), .cpuDone(cpuDone),
  .memReq(memReq), .memWe(memWe), .memAck(memAck), .memAddr(memAddr)
);

// File: tb/dm_wb_cache_bench.sv
`timescale 1ns/100ps
module dm_wb_cache_bench;
  localparam int ADDR_W = 8;
  localparam int LINES  = 8;
  localparam int BB     = 4;
  localparam int OFF_W  = 2;
  localparam int IDX_W  = 3;
  localparam int MEMSZ  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpuReq = 1'b0, cpuWe = 1'b0;
  logic [ADDR_W-1:0] cpuAddr = '0;
  logic [7:0] cpuWdata = '0;
  logic cpuReady, cpuDone, cpuHit;
  logic [7:0] cpuRdata;
  logic memReq, memWe;
  logic [ADDR_W-1:0] memAddr;
  logic [BB*8-1:0] memWdata;
  logic [BB*8-1:0] memRdata = '0;
  logic memAck = 1'b0;

  always #2.5 clk = ~clk;

  dm_wb_cache #(.ADDR_W(ADDR_W), .LINES(LINES), .BLOCK_BYTES(BB)) u_dm_wb_cache (
    .clk(clk), .rst(rst), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuReady(cpuReady), .cpuDone(cpuDone), .cpuHit(cpuHit),
    .cpuRdata(cpuRdata), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck)
  );

  int nChecks = 0;
  int nFail = 0;
  int wbCount = 0;
  int fillCount = 0;
  bit finished = 0;
  logic [ADDR_W-1:0] lastWbAddr, lastFillAddr;
  logic [7:0] backing [MEMSZ];
  logic [7:0] refMem  [MEMSZ];
  logic       mValid [LINES];
  logic       mDirty [LINES];
  logic [ADDR_W-OFF_W-IDX_W-1:0] mTag [LINES];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  endtask

  // backing memory responder
  initial begin
    int delay = 1;
    forever begin
      @(negedge clk);
      if (memAck) memAck = 1'b0;
      else if (memReq) begin
        if (delay == 0) begin
          check("R5 aligned", 32'(memAddr[OFF_W-1:0]), 0);
          if (memWe) begin
            wbCount++;
            lastWbAddr = memAddr;
            for (int b = 0; b < BB; b++) backing[memAddr + b] = memWdata[b*8 +: 8];
          end else begin
            fillCount++;
            lastFillAddr = memAddr;
            for (int b = 0; b < BB; b++) memRdata[b*8 +: 8] = backing[memAddr + b];
          end
          memAck = 1'b1;
          delay = $urandom_range(0, 3);
        end else delay--;
      end
    end
  end

  task automatic access(input logic we, input logic [ADDR_W-1:0] addr, input logic [7:0] data);
    int idx = int'(addr[OFF_W +: IDX_W]);
    logic [ADDR_W-OFF_W-IDX_W-1:0] tag = addr[ADDR_W-1 -: (ADDR_W-OFF_W-IDX_W)];
    logic expHit = mValid[idx] && (mTag[idx] == tag);
    logic expWb = !expHit && mValid[idx] && mDirty[idx];
    logic [ADDR_W-1:0] expWbAddr = {mTag[idx], IDX_W'(idx), {OFF_W{1'b0}}};
    logic [7:0] expRd = refMem[addr];
    int wb0 = wbCount;
    int f0 = fillCount;
    int n = 0;
    bit busyBad = 0;
    if (!expHit) begin mValid[idx] = 1; mTag[idx] = tag; mDirty[idx] = 0; end
    if (we) begin mDirty[idx] = 1; refMem[addr] = data; end
    @(negedge clk);
    while (!cpuReady && n < 100) begin @(negedge clk); n++; end
    cpuReq = 1'b1; cpuWe = we; cpuAddr = addr; cpuWdata = data;
    @(negedge clk);
    cpuReq = 1'b0;
    n = 0;
    while (!cpuDone && n < 200) begin
      if (cpuReady) busyBad = 1;
      @(negedge clk); n++;
    end
    check("R9 ready low while busy", 32'(busyBad), 0);
    check("R9 done seen", 32'(cpuDone), 1);
    check("R2 hit flag", 32'(cpuHit), 32'(expHit));
    if (!we) check("R3 read byte", 32'(cpuRdata), 32'(expRd));
    check(expWb ? "R6 write-back count" : "R7 no write-back", 32'(wbCount - wb0), 32'(expWb));
    if (expWb) check("R6 write-back address", 32'(lastWbAddr), 32'(expWbAddr));
    check("R8 refill count", 32'(fillCount - f0), 32'(!expHit));
    if (!expHit) check("R1 refill address", 32'(lastFillAddr), 32'({addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int bad;
    void'($urandom(32'd4242));
    for (int i = 0; i < MEMSZ; i++) begin
      backing[i] = 8'(i * 7 + 3);
      refMem[i]  = 8'(i * 7 + 3);
    end
    for (int i = 0; i < LINES; i++) begin mValid[i] = 0; mDirty[i] = 0; mTag[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R4 ready after reset", 32'(cpuReady), 1);
    check("R4 memReq low after reset", 32'(memReq), 0);
    // R4/R2: tag 0 line 0 after reset is invalid -> miss
    access(0, 8'h00, 8'h00);
    // R3: every byte of the block, now hitting
    for (int b = 1; b < BB; b++) access(0, 8'(b), 8'h00);
    // R8: write hit then read back
    access(1, 8'h02, 8'hA5);
    access(0, 8'h02, 8'h00);
    // R6: conflicting write miss on dirty line 0
    access(1, 8'h21, 8'h5C);
    access(0, 8'h21, 8'h00);
    access(0, 8'h20, 8'h00);
    // R7: clean read miss on line 3, then conflict on it
    access(0, 8'h0D, 8'h00);
    access(0, 8'hED, 8'h00);
    // R8: write miss to invalid line
    access(1, 8'h57, 8'h3C);
    // random trace
    for (int t = 0; t < 400; t++)
      access(1'($urandom_range(0, 1)), 8'($urandom_range(0, MEMSZ - 1)), 8'($urandom));
    // flush: two conflicting reads per line
    for (int i = 0; i < LINES; i++) begin
      access(0, {3'd0, 3'(i), 2'd0}, 8'h00);
      access(0, {3'd1, 3'(i), 2'd0}, 8'h00);
    end
    bad = 0;
    for (int i = 0; i < MEMSZ; i++) if (backing[i] !== refMem[i]) bad++;
    check("R8 memory image after flush", 32'(bad), 0);
    summary();
  end

endmodule